// File: doc/BRIEF.md
# Condition-Bit Integer Select

This unit returns one of two 64-bit integer operands, chosen by a single bit of a 32-bit condition register. The condition register is treated as eight 4-bit fields. A 5-bit index names the bit to test: its upper three bits pick the field and its lower two bits pick the bit inside that field. Bits inside a field are counted from the most significant end.

When the tested bit is set, the unit returns the first operand. If the caller signals that the first operand's register specifier is zero, it returns a constant zero in its place. When the tested bit is clear, the unit returns the second operand, whatever the specifier flag says.

The caller supplies the operands already read from the register file, together with a valid strobe. One clock later the result appears with a single-cycle valid pulse. The result register holds its value between requests.

Top module: `cond_bit_select`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, `res_valid` is 0 and `res_data` is all zeros.
- R2: `res_valid` is 1 in exactly the cycle after a cycle in which `req_valid` was 1, and 0 otherwise.
- R3: The tested bit for index i (0 to 31) is `cond_reg[31-i]`. Field f = i[4:2] occupies `cond_reg[31-4f:28-4f]`. The low two index bits count inside that field from its most significant bit, so index 0 tests `cond_reg[31]` and index 3 tests `cond_reg[28]`.
- R4: When the tested bit is 1 and `a_spec_zero` is 0, `res_data` becomes `src_a`.
- R5: When the tested bit is 1 and `a_spec_zero` is 1, `res_data` becomes zero, whatever `src_a` holds.
- R6: When the tested bit is 0, `res_data` becomes `src_b`, whatever `a_spec_zero` holds.
- R7: In a cycle with `req_valid` at 0, `res_data` keeps its previous value, even when the other inputs change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request strobe; the inputs are sampled when it is 1 |
| cond_reg | input | 32 | Condition register; eight 4-bit fields, field 0 in the top nibble |
| bit_sel | input | 5 | Index of the condition bit to test |
| a_spec_zero | input | 1 | The first operand's specifier is zero; use a constant 0 for it |
| src_a | input | 64 | First operand |
| src_b | input | 64 | Second operand |
| res_data | output | 64 | Selected result, registered |
| res_valid | output | 1 | One-cycle pulse marking a new result |

## Verification
The bench sweeps all 32 indices in two ways. First it sets only the addressed bit in `cond_reg`. Then it clears only that bit and sets all the others. A design that counted bits from the wrong end of a field, or that numbered the fields from the bottom of the register, would pick a neighbouring bit and return the wrong operand for most indices. Each index is also run with the zero-specifier flag both set and clear. This catches a design that forced zero on the wrong branch, for example one that zeroed the result when the tested bit was clear. Idle cycles with changed inputs follow some requests, to catch a result register that updates without a request or a valid flag that stays high.

// File: rtl/cond_bit_select.sv
module cond_bit_select #(
  parameter int DATA_W = 64,
  parameter int FIELDS = 8,
  parameter int FW     = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [31:0]       cond_reg,
  input  logic [4:0]        bit_sel,
  input  logic              a_spec_zero,
  input  logic [DATA_W-1:0] src_a,
  input  logic [DATA_W-1:0] src_b,
  output logic [DATA_W-1:0] res_data,
  output logic              res_valid
);
  localparam int CR_W   = FIELDS * FW;
  localparam int FSEL_W = $clog2(FIELDS);
  localparam int BSEL_W = $clog2(FW);
  localparam int IDX_W  = FSEL_W + BSEL_W;

  logic [FSEL_W-1:0] fsel;
  logic [BSEL_W-1:0] bsel;
  logic [FW-1:0]     field;
  logic              hit;
  logic [DATA_W-1:0] a_eff;
  logic [DATA_W-1:0] pick;

  assign fsel = bit_sel[IDX_W-1 -: FSEL_W];
  assign bsel = bit_sel[BSEL_W-1:0];

  // field 0 sits in the top nibble; bits inside a field count from the MSB
  always_comb begin
    field = cond_reg[(CR_W-1) - FW*int'(fsel) -: FW];
    hit   = field[(FW-1) - int'(bsel)];
  end

  assign a_eff = a_spec_zero ? '0 : src_a;
  assign pick  = hit ? a_eff : src_b;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      res_data  <= '0;
      res_valid <= 1'b0;
    end else begin
      res_valid <= req_valid;
      if (req_valid) res_data <= pick;
    end
  end

  a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> res_valid);
  a_r2_no_spurious_valid: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> !res_valid);
  a_r4_take_a: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && cond_reg[CR_W-1-int'(bit_sel)] && !a_spec_zero)
      |=> res_data == $past(src_a));
  a_r5_force_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && cond_reg[CR_W-1-int'(bit_sel)] && a_spec_zero)
      |=> res_data == '0);
  a_r6_take_b: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !cond_reg[CR_W-1-int'(bit_sel)])
      |=> res_data == $past(src_b));
  a_r7_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> $stable(res_data));
endmodule

// File: tb/sim_cond_bit_select.sv
module sim_cond_bit_select;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [31:0] cond_reg = '0;
  logic [4:0]  bit_sel = '0;
  logic        a_spec_zero = 1'b0;
  logic [63:0] src_a = '0;
  logic [63:0] src_b = '0;
  logic [63:0] res_data;
  logic        res_valid;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  cond_bit_select u0 (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .cond_reg(cond_reg),
    .bit_sel(bit_sel), .a_spec_zero(a_spec_zero), .src_a(src_a), .src_b(src_b),
    .res_data(res_data), .res_valid(res_valid)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // drive one request at a falling edge; result is visible one falling edge later
  task automatic run(input logic [31:0] cr, input int idx, input logic z,
                     input logic [63:0] a, input logic [63:0] b, input bit hold);
    logic        bitv;
    logic [63:0] exp;
    bitv = cr[31-idx];                      // R3: index i tests cond_reg[31-i]
    exp  = bitv ? (z ? 64'h0 : a) : b;      // R4 R5 R6
    @(negedge clk);
    cond_reg = cr; bit_sel = 5'(idx); a_spec_zero = z; src_a = a; src_b = b;
    req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R2 valid pulse", {63'h0, res_valid}, 64'h1);
    if (!bitv)      chk("R6 take b", res_data, exp);
    else if (z)     chk("R5 force zero", res_data, exp);
    else            chk("R4 take a", res_data, exp);
    chk("R3 bit position", res_data, exp);
    if (hold) begin
      cond_reg = ~cr; a_spec_zero = ~z; src_a = ~a; src_b = ~b;
      @(negedge clk);
      chk("R2 valid drops", {63'h0, res_valid}, 64'h0);
      chk("R7 hold when idle", res_data, exp);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset valid", {63'h0, res_valid}, 64'h0);
    chk("R1 reset data", res_data, 64'h0);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 after reset valid", {63'h0, res_valid}, 64'h0);
    chk("R1 after reset data", res_data, 64'h0);

    for (int i = 0; i < 32; i++) begin
      logic [63:0] a, b;
      a = 64'hA5A5_0000_0000_0000 | 64'(i * 97 + 1);
      b = 64'h5A5A_FFFF_0000_0000 | 64'(i * 131 + 7);
      run(32'h1 << (31 - i),    i, 1'b0, a, b, (i % 4) == 0);
      run(32'h1 << (31 - i),    i, 1'b1, a, b, (i % 5) == 1);
      run(~(32'h1 << (31 - i)), i, 1'b0, a, b, (i % 3) == 2);
      run(~(32'h1 << (31 - i)), i, 1'b1, a, b, 1'b0);
    end
    // back-to-back requests keep valid high
    run(32'h8000_0000, 0, 1'b0, 64'h1111, 64'h2222, 1'b0);
    @(negedge clk);
    cond_reg = 32'h0000_0001; bit_sel = 5'd31; a_spec_zero = 1'b0;
    src_a = 64'hDEAD; src_b = 64'hBEEF; req_valid = 1'b1;
    @(negedge clk);
    cond_reg = 32'h0000_0000; bit_sel = 5'd31;
    @(negedge clk);
    req_valid = 1'b0;
    chk("R2 back-to-back valid", {63'h0, res_valid}, 64'h1);
    chk("R6 second of pair", res_data, 64'hBEEF);
    @(negedge clk);
    chk("R2 valid ends", {63'h0, res_valid}, 64'h0);

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule